// File: doc/BRIEF.md
# Multi-Core Interrupt Summary Controller

This block collects raw interrupt sources and steers them to nine target interrupt lines: two lines for each of four processor cores, plus one line for a PCIe root-complex target. Each target keeps its own private summary of the first 64-bit source group. Sixteen general-purpose pin interrupts are folded into that group. A second 64-bit source group is summarised once and shared by all targets, and every target gates it through its own enable mask. Each core also has a third interrupt line, fed by a separate per-core source vector with its own summary and enable.

Each summary bit is sticky. It is set on every cycle its source is high, and software clears it by writing 1 to it once the source has gone low. Each target line drives a level interrupt and a 7-bit hardware interrupt number. In that number, bit 6 gives the group and bits 5:0 give the bit position, so group = number >> 6 and bit = number & 63. Software reads and writes the summaries and enables through a small request port. A read returns its data one cycle after the request.

Top module: `intsum_ctrl`

The register port has two states. PORT_IDLE moves to PORT_RESP when a read request is seen. PORT_RESP moves to PORT_IDLE unless another read request arrives, in which case it stays in PORT_RESP. `cfg_rvalid` is high exactly while the port is in PORT_RESP.

Address map (`cfg_addr` is 6 bits):

| Address | Register |
|---|---|
| 0x00+t | First-group summary of target t (t = 0..8) |
| 0x10+t | First-group enable of target t |
| 0x20+t | Second-group enable of target t |
| 0x30 | Shared second-group summary |
| 0x38+c | Third-line summary of core c (c = 0..3) |
| 0x3C+c | Third-line enable of core c |

Target numbering is t = 2·core + line, and t = 8 is the PCIe root-complex target.

## Requirements
- R1: After reset all summaries and enables are zero, every interrupt output is low, every interrupt number is 0 and `cfg_rvalid` is low.
- R2: A read request (`cfg_req`=1, `cfg_we`=0) returns the addressed register on `cfg_rdata` with `cfg_rvalid`=1 in the following cycle. A write (`cfg_we`=1) to an enable register loads `cfg_wdata`. Unmapped addresses read as 0.
- R3: A summary bit is set on every clock edge at which its source is high. Writing 1 to the bit clears it only if its source is low at that edge, and writing 0 leaves it unchanged.
- R4: Reads return summaries unmasked; enables affect only the interrupt outputs.
- R5: Each of the nine targets has an independent first-group summary. Clearing one target's summary leaves the others unchanged. `tgt_irq[t]` is high when (first-group summary[t] AND first-group enable[t]) is non-zero.
- R6: The second group has one shared summary. `tgt_irq[t]` is also high when (shared summary AND second-group enable[t]) is non-zero.
- R7: `tgt_num[7t+6:7t]` is {group, bit}. The first group takes precedence over the second, and within a group the most significant enabled pending bit is chosen. The number is 0 when nothing is pending.
- R8: `gpio_in[i]` drives bit 16+i of the first source group, and bits 31:16 of `grp0_src` have no effect.
- R9: For each core c, `l3_irq[c]` is high when (third-line summary[c] AND third-line enable[c]) is non-zero. `l3_idx[6c+5:6c]` is the most significant such bit, or 0 when none is pending.
- R10: Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| grp0_src | input | 64 | First-group raw sources (bits 31:16 unused) |
| gpio_in | input | 16 | Pin interrupts, placed at first-group bits 31:16 |
| grp1_src | input | 64 | Second-group raw sources |
| core_src | input | 256 | Third-line raw sources, 64 bits per core |
| cfg_req | input | 1 | Register access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data |
| cfg_rvalid | output | 1 | Read data valid |
| tgt_irq | output | 9 | Level interrupt per target line |
| tgt_num | output | 63 | Hardware interrupt number per target, 7 bits each |
| l3_irq | output | 4 | Third-line level interrupt per core |
| l3_idx | output | 24 | Third-line highest pending bit per core, 6 bits each |

## Verification
The assertions check several properties on every cycle:
- each target's interrupt number points at an enabled, pending bit with no higher bit pending in its group, and the second group is chosen only when the first group has nothing pending;
- a raw source that was high is always present in the shared summary one cycle later;
- a target interrupt never fires while both of its enables are zero;
- the read-valid flag follows read requests exactly.

Only the bench scenarios can show the register address decode and the pin placement at bits 16 to 31. They also cover the write-1-to-clear rule when the source is low, the independence of the nine first-group summaries, and the absence of side effects from unmapped writes.

// File: rtl/intsum_pkg.sv
package intsum_pkg;

    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_RESP = 1'b1
    } port_state_e;

    localparam int ADDR_W = 6;

    localparam logic [1:0] SP_SUM0 = 2'd0;
    localparam logic [1:0] SP_EN0  = 2'd1;
    localparam logic [1:0] SP_EN1  = 2'd2;
    localparam logic [1:0] SP_MISC = 2'd3;

    localparam logic [3:0] MISC_SUM1   = 4'd0;
    localparam logic [3:0] MISC_L3_SUM = 4'd8;
    localparam logic [3:0] MISC_L3_EN  = 4'd12;

endpackage

// File: rtl/intsum_msb.sv
module intsum_msb #(
    parameter int W     = 64,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/intsum_target.sv
module intsum_target #(
    parameter int W     = 64,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     sum0,
    input  logic [W-1:0]     en0,
    input  logic [W-1:0]     sum1,
    input  logic [W-1:0]     en1,
    output logic             irq,
    output logic [IDX_W:0]   num
);
    logic [W-1:0]     m0, m1;
    logic [IDX_W-1:0] idx0, idx1;
    logic             any0, any1;

    assign m0 = sum0 & en0;
    assign m1 = sum1 & en1;

    intsum_msb #(.W(W), .IDX_W(IDX_W)) u_msb0 (.vec(m0), .idx(idx0), .any(any0));
    intsum_msb #(.W(W), .IDX_W(IDX_W)) u_msb1 (.vec(m1), .idx(idx1), .any(any1));

    always_comb begin
        irq = any0 | any1;
        if (any0)      num = {1'b0, idx0};
        else if (any1) num = {1'b1, idx1};
        else           num = '0;
    end

    // R7: a first-group number names an enabled pending bit with nothing above it
    a_r7_grp0_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !num[IDX_W]) |-> ((m0 >> num[IDX_W-1:0]) == W'(1)));

    // R7: the second group is chosen only while the first group is idle
    a_r7_grp1_only_when_grp0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && num[IDX_W]) |-> (m0 == '0 && ((m1 >> num[IDX_W-1:0]) == W'(1))));
endmodule

// File: rtl/intsum_port.sv
module intsum_port
    import intsum_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [DATA_W-1:0] rd_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    port_state_e state_q, state_d;
    logic        rd_req;

    assign rd_req = req & ~we;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: if (rd_req) state_d = PORT_RESP;
            PORT_RESP: if (!rd_req) state_d = PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_req) rdata <= rd_in;
    end

    assign rvalid = (state_q == PORT_RESP);

    // R2: read data valid exactly one cycle after a read request
    a_r2_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    a_r2_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid);
endmodule

// File: rtl/intsum_ctrl.sv
module intsum_ctrl
    import intsum_pkg::*;
#(
    parameter int NUM_CORES      = 4,
    parameter int LINES_PER_CORE = 2,
    parameter int SRC_W          = 64,
    parameter int GPIO_N         = 16,
    parameter int GPIO_LSB       = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SRC_W-1:0]                grp0_src,
    input  logic [GPIO_N-1:0]               gpio_in,
    input  logic [SRC_W-1:0]                grp1_src,
    input  logic [NUM_CORES*SRC_W-1:0]      core_src,
    input  logic                            cfg_req,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [SRC_W-1:0]                cfg_wdata,
    output logic [SRC_W-1:0]                cfg_rdata,
    output logic                            cfg_rvalid,
    output logic [NUM_CORES*LINES_PER_CORE:0] tgt_irq,
    output logic [(NUM_CORES*LINES_PER_CORE+1)*($clog2(SRC_W)+1)-1:0] tgt_num,
    output logic [NUM_CORES-1:0]            l3_irq,
    output logic [NUM_CORES*$clog2(SRC_W)-1:0] l3_idx
);
    localparam int NUM_TGT = NUM_CORES * LINES_PER_CORE + 1;
    localparam int IDX_W   = $clog2(SRC_W);
    localparam int NUM_W   = IDX_W + 1;
    localparam logic [SRC_W-1:0] GPIO_MASK =
        ((SRC_W'(1) << GPIO_N) - SRC_W'(1)) << GPIO_LSB;

    logic [SRC_W-1:0] sum0_q [NUM_TGT];
    logic [SRC_W-1:0] en0_q  [NUM_TGT];
    logic [SRC_W-1:0] en1_q  [NUM_TGT];
    logic [SRC_W-1:0] sum1_q;
    logic [SRC_W-1:0] l3sum_q [NUM_CORES];
    logic [SRC_W-1:0] l3en_q  [NUM_CORES];

    logic [SRC_W-1:0] grp0_raw;
    logic [SRC_W-1:0] rd_mux;
    logic             wr;
    logic [1:0]       space;
    logic [3:0]       sel;

    assign grp0_raw = (grp0_src & ~GPIO_MASK) | (SRC_W'(gpio_in) << GPIO_LSB);
    assign wr    = cfg_req & cfg_we;
    assign space = cfg_addr[5:4];
    assign sel   = cfg_addr[3:0];

    // Register file: sticky summaries with write-1-to-clear, plain enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TGT; t++) begin
                sum0_q[t] <= '0;
                en0_q[t]  <= '0;
                en1_q[t]  <= '0;
            end
            for (int c = 0; c < NUM_CORES; c++) begin
                l3sum_q[c] <= '0;
                l3en_q[c]  <= '0;
            end
            sum1_q <= '0;
        end else begin
            for (int t = 0; t < NUM_TGT; t++) begin
                sum0_q[t] <= grp0_raw | (sum0_q[t] &
                    ~((wr && space == SP_SUM0 && sel == t[3:0]) ? cfg_wdata : '0));
                if (wr && space == SP_EN0 && sel == t[3:0]) en0_q[t] <= cfg_wdata;
                if (wr && space == SP_EN1 && sel == t[3:0]) en1_q[t] <= cfg_wdata;
            end
            sum1_q <= grp1_src | (sum1_q &
                ~((wr && space == SP_MISC && sel == MISC_SUM1) ? cfg_wdata : '0));
            for (int c = 0; c < NUM_CORES; c++) begin
                l3sum_q[c] <= core_src[c*SRC_W +: SRC_W] | (l3sum_q[c] &
                    ~((wr && space == SP_MISC && sel == MISC_L3_SUM + c[3:0]) ? cfg_wdata : '0));
                if (wr && space == SP_MISC && sel == MISC_L3_EN + c[3:0]) l3en_q[c] <= cfg_wdata;
            end
        end
    end

    // Read decode (unmasked summaries)
    always_comb begin
        rd_mux = '0;
        unique case (space)
            SP_SUM0: for (int t = 0; t < NUM_TGT; t++) if (sel == t[3:0]) rd_mux = sum0_q[t];
            SP_EN0:  for (int t = 0; t < NUM_TGT; t++) if (sel == t[3:0]) rd_mux = en0_q[t];
            SP_EN1:  for (int t = 0; t < NUM_TGT; t++) if (sel == t[3:0]) rd_mux = en1_q[t];
            SP_MISC: begin
                if (sel == MISC_SUM1) rd_mux = sum1_q;
                for (int c = 0; c < NUM_CORES; c++) begin
                    if (sel == MISC_L3_SUM + c[3:0]) rd_mux = l3sum_q[c];
                    if (sel == MISC_L3_EN + c[3:0])  rd_mux = l3en_q[c];
                end
            end
            default: rd_mux = '0;
        endcase
    end

    intsum_port #(.DATA_W(SRC_W)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (cfg_req),
        .we     (cfg_we),
        .rd_in  (rd_mux),
        .rdata  (cfg_rdata),
        .rvalid (cfg_rvalid)
    );

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        intsum_target #(.W(SRC_W), .IDX_W(IDX_W)) u_tgt (
            .clk   (clk),
            .rst_n (rst_n),
            .sum0  (sum0_q[t]),
            .en0   (en0_q[t]),
            .sum1  (sum1_q),
            .en1   (en1_q[t]),
            .irq   (tgt_irq[t]),
            .num   (tgt_num[t*NUM_W +: NUM_W])
        );

        // R5/R6: a target line never fires with both of its enables cleared
        a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_irq[t] |-> ((en0_q[t] | en1_q[t]) != '0));
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_l3
        logic [SRC_W-1:0] l3_masked;
        assign l3_masked = l3sum_q[c] & l3en_q[c];
        intsum_msb #(.W(SRC_W), .IDX_W(IDX_W)) u_msb (
            .vec (l3_masked),
            .idx (l3_idx[c*IDX_W +: IDX_W]),
            .any (l3_irq[c])
        );

        // R9: third-line output only with an enabled pending bit
        a_r9_l3_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
            l3_irq[c] |-> l3_masked[l3_idx[c*IDX_W +: IDX_W]]);
    end

    // R3: a source high at one edge is present in the summary afterwards
    a_r3_live_source_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sum1_q & $past(grp1_src)) == $past(grp1_src)));
endmodule

// File: tb/intsum_ctrl_test.sv
`timescale 1ns/1ps
module intsum_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  grp0_src = '0;
    logic [15:0]  gpio_in = '0;
    logic [63:0]  grp1_src = '0;
    logic [255:0] core_src = '0;
    logic         cfg_req = 1'b0;
    logic         cfg_we = 1'b0;
    logic [5:0]   cfg_addr = '0;
    logic [63:0]  cfg_wdata = '0;
    logic [63:0]  cfg_rdata;
    logic         cfg_rvalid;
    logic [8:0]   tgt_irq;
    logic [62:0]  tgt_num;
    logic [3:0]   l3_irq;
    logic [23:0]  l3_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    intsum_ctrl uut (
        .clk(clk), .rst_n(rst_n), .grp0_src(grp0_src), .gpio_in(gpio_in),
        .grp1_src(grp1_src), .core_src(core_src), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .tgt_irq(tgt_irq), .tgt_num(tgt_num),
        .l3_irq(l3_irq), .l3_idx(l3_idx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [63:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = a;
        @(negedge clk);
        check("R2 rvalid", {63'd0, cfg_rvalid}, 64'd1);
        d = cfg_rdata;
        cfg_req = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        grp0_src = '0; gpio_in = '0; grp1_src = '0; core_src = '0;
        for (int t = 0; t < 9; t++) begin
            reg_write(6'h00 + 6'(t), '1);
            reg_write(6'h10 + 6'(t), '0);
            reg_write(6'h20 + 6'(t), '0);
        end
        reg_write(6'h30, '1);
        for (int c = 0; c < 4; c++) begin
            reg_write(6'h38 + 6'(c), '1);
            reg_write(6'h3C + 6'(c), '0);
        end
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R1 tgt_irq", 64'(tgt_irq), 64'd0);
        check("R1 tgt_num", 64'(tgt_num[13:0]), 64'd0);
        check("R1 l3_irq", 64'(l3_irq), 64'd0);
        check("R1 rvalid", 64'(cfg_rvalid), 64'd0);
        reg_read(6'h13, d); check("R1 en0[3]", d, 64'd0);
        reg_read(6'h30, d); check("R1 sum1", d, 64'd0);
        @(negedge clk);
        check("R2 rvalid drops", 64'(cfg_rvalid), 64'd0);
    endtask

    task automatic t_port();
        logic [63:0] d;
        clear_all();
        reg_write(6'h12, 64'hDEAD_BEEF_0123_4567);
        reg_read(6'h12, d); check("R2 en0[2] readback", d, 64'hDEAD_BEEF_0123_4567);
        reg_read(6'h0F, d); check("R2 unmapped read", d, 64'd0);
        reg_write(6'h31, '1);
        reg_write(6'h1F, '1);
        reg_read(6'h30, d); check("R10 sum1 untouched", d, 64'd0);
        reg_read(6'h11, d); check("R10 en0[1] untouched", d, 64'd0);
        reg_read(6'h3C, d); check("R10 l3en[0] untouched", d, 64'd0);
    endtask

    task automatic t_sticky();
        logic [63:0] d;
        clear_all();
        grp1_src = 64'h20;
        @(negedge clk);
        reg_write(6'h30, 64'h20);
        reg_read(6'h30, d); check("R3 clear ignored while source high", d, 64'h20);
        grp1_src = '0;
        @(negedge clk);
        reg_read(6'h30, d); check("R3 bit stays after source drops", d, 64'h20);
        reg_write(6'h30, 64'h0);
        reg_read(6'h30, d); check("R3 write 0 keeps bit", d, 64'h20);
        reg_write(6'h30, 64'h20);
        reg_read(6'h30, d); check("R3 clear once source low", d, 64'h0);
    endtask

    task automatic t_unmasked();
        logic [63:0] d;
        clear_all();
        grp0_src = 64'h8000_0000_0000_0001;
        @(negedge clk);
        check("R4 no irq without enable", 64'(tgt_irq), 64'd0);
        reg_read(6'h00, d); check("R4 unmasked read", d, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_group0();
        logic [63:0] d;
        clear_all();
        grp0_src = 64'd1 << 40;
        reg_write(6'h13, 64'd1 << 40);
        check("R5 only target 3 fires", 64'(tgt_irq), 64'h8);
        grp0_src = '0;
        reg_write(6'h03, '1);
        reg_read(6'h03, d); check("R5 target 3 summary cleared", d, 64'd0);
        reg_read(6'h04, d); check("R5 target 4 summary independent", d, 64'd1 << 40);
        check("R5 irq drops after clear", 64'(tgt_irq), 64'd0);
    endtask

    task automatic t_group1();
        clear_all();
        grp1_src = 64'd1 << 10;
        reg_write(6'h20, 64'd1 << 10);
        reg_write(6'h28, 64'd1 << 10);
        check("R6 shared summary to targets 0 and 8", 64'(tgt_irq), 64'h101);
        check("R6 target 8 number", 64'(tgt_num[8*7 +: 7]), 64'd74);
    endtask

    task automatic t_prio();
        clear_all();
        grp0_src = (64'd1 << 3) | (64'd1 << 50);
        grp1_src = 64'd1 << 60;
        reg_write(6'h11, '1);
        reg_write(6'h21, '1);
        check("R7 group0 msb first", 64'(tgt_num[1*7 +: 7]), 64'd50);
        grp0_src = '0;
        reg_write(6'h01, '1);
        check("R7 group1 after group0 empty", 64'(tgt_num[1*7 +: 7]), 64'd124);
        grp1_src = '0;
        reg_write(6'h30, '1);
        check("R7 none pending", 64'(tgt_num[1*7 +: 7]), 64'd0);
        check("R7 irq low", 64'(tgt_irq[1]), 64'd0);
    endtask

    task automatic t_gpio();
        logic [63:0] d;
        clear_all();
        gpio_in = 16'h0004;
        @(negedge clk);
        reg_read(6'h00, d); check("R8 gpio2 to bit 18", d, 64'd1 << 18);
        gpio_in = '0;
        reg_write(6'h00, '1);
        grp0_src = 64'h0000_0000_FFFF_0000;
        @(negedge clk);
        reg_read(6'h00, d); check("R8 raw bits 31:16 ignored", d, 64'd0);
    endtask

    task automatic t_line3();
        logic [63:0] d;
        clear_all();
        core_src[2*64 + 33] = 1'b1;
        core_src[2*64 + 7] = 1'b1;
        reg_write(6'h3E, '1);
        check("R9 core2 line3 irq", 64'(l3_irq), 64'h4);
        check("R9 core2 idx", 64'(l3_idx[2*6 +: 6]), 64'd33);
        reg_read(6'h3A, d); check("R9 core2 summary", d, (64'd1 << 33) | (64'd1 << 7));
        check("R9 core0 idx idle", 64'(l3_idx[5:0]), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_port();
        t_sticky();
        t_unmasked();
        t_group0();
        t_group1();
        t_prio();
        t_gpio();
        t_line3();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule